// File: doc/BRIEF.md
# Host-to-Controller Byte Mailbox

This block passes bytes between a host register port and a small microcontroller. The host sees three 32-bit word slots: a control word holding interrupt masks and requests, a data word that feeds an outgoing queue when written and drains an incoming queue when read, and a status word whose flags are latched and cleared by writing 1. The controller side has a byte valid/ready pair in each direction. Both queues are first-in first-out, with a depth set by a parameter (8 by default).

Status flags capture queue conditions and keep them until the host clears them. A condition that still holds sets its flag again one clock after the clear. The receive-overflow flag records a byte that the controller offered while the incoming queue was full. It stays set until the host clears it. Each interrupt request is the AND of a status flag and its mask bit. A single interrupt line is high whenever any request is active.

Top module: `mcu_mailbox`

## Requirements
- R1: Word slots are decoded from address bits [3:2]: 0 is the control word, 1 the data word, 2 the status word. Bits 31:8 of every read are 0. Slot 3 reads as 0, and writes to it change nothing.
- R2: Status bit 0 means the outgoing queue is empty, bit 1 that it is not full, bit 2 that the incoming queue holds data, and bit 3 that an incoming byte was lost. A flag is set at the clock edge where its condition is seen. It stays set after the condition ends.
- R3: Writing 1 to a status bit clears it at that edge, and writing 0 leaves it alone. If the condition of bit 0, 1 or 2 still holds, that bit reads 1 again after the following edge.
- R4: When rx_valid is high while the incoming queue is full, the byte is discarded and status bit 3 is set. Bit 3 stays set until cleared. If the overflow and a clear happen on the same edge, bit 3 stays set.
- R5: Control-word bits 7:4 are mask bits, which are read/write and reset to 0. Bits 3:0 are read-only requests, each equal to status bit n AND mask bit 4+n. Writes to bits 3:0 are ignored.
- R6: irq is high exactly when some request bit is 1.
- R7: A write to the data word appends bits 7:0 to the outgoing queue. When the queue already holds FIFO_DEPTH bytes, the write is ignored.
- R8: A read of the data word returns the oldest incoming byte and removes it. A read while the incoming queue is empty returns 0 and removes nothing.
- R9: tx_valid is high while the outgoing queue holds data. Bytes leave in write order, and tx_data stays stable until tx_ready accepts it.
- R10: rx_ready is high while the incoming queue has room. A byte is stored on an edge where rx_valid and rx_ready are both high.
- R11: While reset is held, the status word, masks and irq are 0 and both queues are empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_sel | input | 1 | Register access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address of the word slot |
| bus_wdata | input | 32 | Write data (bits 7:0 significant) |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| tx_valid | output | 1 | Outgoing byte available |
| tx_ready | input | 1 | Controller takes the outgoing byte |
| tx_data | output | 8 | Outgoing byte |
| rx_valid | input | 1 | Controller offers an incoming byte |
| rx_ready | output | 1 | Incoming queue has room |
| rx_data | input | 8 | Incoming byte |
| irq | output | 1 | Any enabled request active |

## Verification
The bench builds the block with FIFO_DEPTH set to 4. With that depth, both queues can be filled, overfilled and drained within a handful of cycles, so the full-write drop, the lost-byte flag and the empty read are all exercised at the real queue boundary. The full mask space of 16 values is swept against a known status word, and every request bit and the irq line are computed arithmetically. Clear timing is checked cycle by cycle, including a clear that coincides with an overflow.

// File: rtl/mbx_pkg.sv
// Shared constants for the mailbox: word slot indices and status bit indices.
// Assumes 32-bit word slots addressed by byte offset.
package mbx_pkg;
    localparam int unsigned SLOT_CTRL = 0;
    localparam int unsigned SLOT_DATA = 1;
    localparam int unsigned SLOT_STAT = 2;

    localparam int unsigned NUM_SRC   = 4;
    localparam int unsigned ST_TXE    = 0;
    localparam int unsigned ST_TXNF   = 1;
    localparam int unsigned ST_RXNE   = 2;
    localparam int unsigned ST_RXO    = 3;

    // bits whose set event has priority over a same-cycle clear
    localparam logic [NUM_SRC-1:0] EVT_WINS = 4'b1000;
endpackage

// File: rtl/mbx_fifo.sv
// Synchronous FIFO with first-word-fall-through output.
// Assumes the caller never pushes when full or pops when empty; both are
// gated here as well so misuse leaves state unchanged.
module mbx_fifo #(
    parameter int unsigned WIDTH = 8,
    parameter int unsigned DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    output logic [WIDTH-1:0] dout,
    output logic             empty,
    output logic             full
);
    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CNT_W = $clog2(DEPTH + 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] count;
    logic             do_push, do_pop;

    assign empty   = (count == '0);
    assign full    = (count == CNT_W'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rd_ptr];

    // Storage write; contents need no reset.
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= din;
    end

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push)
                wr_ptr <= (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            if (do_pop)
                rd_ptr <= (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/mbx_status.sv
// Latched status flags with write-1-to-clear.
// Each flag sets on the edge where its condition is high. For bits marked in
// EVT_MASK a set beats a same-cycle clear; for the others the clear wins,
// and the flag re-sets on the following edge if the condition persists.
module mbx_status #(
    parameter int unsigned          N        = 4,
    parameter logic [N-1:0]         EVT_MASK = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] cond,
    input  logic [N-1:0] clr,
    output logic [N-1:0] flags
);
    for (genvar i = 0; i < N; i++) begin : g_flag
        if (EVT_MASK[i]) begin : g_evt
            // Event flag: set has priority, so no event is lost to a clear.
            always_ff @(posedge clk) begin
                if (!rst_n)       flags[i] <= 1'b0;
                else if (cond[i]) flags[i] <= 1'b1;
                else if (clr[i])  flags[i] <= 1'b0;
            end
        end else begin : g_lvl
            // Level flag: clear has priority for one edge.
            always_ff @(posedge clk) begin
                if (!rst_n)       flags[i] <= 1'b0;
                else if (clr[i])  flags[i] <= 1'b0;
                else if (cond[i]) flags[i] <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/mbx_irqctl.sv
// Interrupt masking: holds the per-source mask bits and forms the request
// vector and the combined interrupt line. Assumes flags are registered.
module mbx_irqctl #(
    parameter int unsigned N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         mask_we,
    input  logic [N-1:0] mask_in,
    input  logic [N-1:0] flags,
    output logic [N-1:0] mask_q,
    output logic [N-1:0] req,
    output logic         irq
);
    // Mask register, written from the control word.
    always_ff @(posedge clk) begin
        if (!rst_n)       mask_q <= '0;
        else if (mask_we) mask_q <= mask_in;
    end

    assign req = flags & mask_q;
    assign irq = |req;
endmodule

// File: rtl/mcu_mailbox.sv
// Byte mailbox between a host register port and a microcontroller.
// Host side: single-cycle accesses; read data is combinational in the access
// cycle and a data-word read pops at the end of that cycle.
// Controller side: valid/ready byte streams in each direction.
module mcu_mailbox #(
    parameter int unsigned BUS_W      = 32,
    parameter int unsigned BYTE_W     = 8,
    parameter int unsigned ADDR_W     = 4,
    parameter int unsigned FIFO_DEPTH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    output logic              tx_valid,
    input  logic              tx_ready,
    output logic [BYTE_W-1:0] tx_data,
    input  logic              rx_valid,
    output logic              rx_ready,
    input  logic [BYTE_W-1:0] rx_data,
    output logic              irq
);
    import mbx_pkg::*;

    localparam int unsigned SLOT_W = ADDR_W - 2;
    localparam int unsigned NS     = NUM_SRC;

    logic [SLOT_W-1:0] slot;
    logic              hit_ctrl, hit_data, hit_stat;
    logic              data_wr, data_rd;
    logic              tx_empty, tx_full, rx_empty, rx_full;
    logic              tx_push, rx_push, rx_pop, ovf_evt;
    logic [BYTE_W-1:0] rx_head;
    logic [NS-1:0]     cond, clr, sta_q, mask_q, req;
    logic              mask_we;
    logic              unused_bits;

    assign slot     = bus_addr[ADDR_W-1:2];
    assign hit_ctrl = bus_sel && (slot == SLOT_W'(SLOT_CTRL));
    assign hit_data = bus_sel && (slot == SLOT_W'(SLOT_DATA));
    assign hit_stat = bus_sel && (slot == SLOT_W'(SLOT_STAT));
    assign data_wr  = hit_data && bus_wr;
    assign data_rd  = hit_data && !bus_wr;
    assign mask_we  = hit_ctrl && bus_wr;
    assign clr      = (hit_stat && bus_wr) ? bus_wdata[NS-1:0] : '0;
    assign unused_bits = ^{bus_wdata[BUS_W-1:2*NS], bus_addr[1:0]};

    assign tx_push  = data_wr && !tx_full;
    assign rx_push  = rx_valid && !rx_full;
    assign rx_pop   = data_rd && !rx_empty;
    assign ovf_evt  = rx_valid && rx_full;
    assign tx_valid = !tx_empty;
    assign rx_ready = !rx_full;

    mbx_fifo #(.WIDTH(BYTE_W), .DEPTH(FIFO_DEPTH)) u_tx_fifo (
        .clk(clk), .rst_n(rst_n),
        .push(tx_push), .din(bus_wdata[BYTE_W-1:0]),
        .pop(tx_valid && tx_ready), .dout(tx_data),
        .empty(tx_empty), .full(tx_full)
    );

    mbx_fifo #(.WIDTH(BYTE_W), .DEPTH(FIFO_DEPTH)) u_rx_fifo (
        .clk(clk), .rst_n(rst_n),
        .push(rx_push), .din(rx_data),
        .pop(rx_pop), .dout(rx_head),
        .empty(rx_empty), .full(rx_full)
    );

    // Condition vector in status bit order.
    always_comb begin
        cond          = '0;
        cond[ST_TXE]  = tx_empty;
        cond[ST_TXNF] = !tx_full;
        cond[ST_RXNE] = !rx_empty;
        cond[ST_RXO]  = ovf_evt;
    end

    mbx_status #(.N(NS), .EVT_MASK(EVT_WINS)) u_status (
        .clk(clk), .rst_n(rst_n), .cond(cond), .clr(clr), .flags(sta_q)
    );

    mbx_irqctl #(.N(NS)) u_irq (
        .clk(clk), .rst_n(rst_n), .mask_we(mask_we),
        .mask_in(bus_wdata[2*NS-1:NS]), .flags(sta_q),
        .mask_q(mask_q), .req(req), .irq(irq)
    );

    // Read data multiplexer for the word slots.
    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_wr) begin
            if (hit_ctrl)
                bus_rdata[2*NS-1:0] = {mask_q, req};
            else if (hit_data && !rx_empty)
                bus_rdata[BYTE_W-1:0] = rx_head;
            else if (hit_stat)
                bus_rdata[NS-1:0] = sta_q;
        end
    end
endmodule

// File: rtl/mbx_checker.sv
// Protocol and state properties of the mailbox, bound onto mcu_mailbox.
// Assumes status bit order: empty, not-full, rx-not-empty, overflow.
module mbx_checker #(
    parameter int unsigned ADDR_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic              tx_valid,
    input logic              tx_ready,
    input logic [7:0]        tx_data,
    input logic              rx_valid,
    input logic              rx_ready,
    input logic              irq,
    input logic [3:0]        sta,
    input logic [3:0]        mask
);
    logic stat_wr, data_rd;
    assign stat_wr = bus_sel && bus_wr && (bus_addr[ADDR_W-1:2] == 2);
    assign data_rd = bus_sel && !bus_wr && (bus_addr[ADDR_W-1:2] == 1);

    assert_ovf_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !rx_ready) |=> sta[3]);

    assert_ovf_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (sta[3] && !(stat_wr && bus_wdata[3])) |=> sta[3]);

    assert_clear_empty_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_wr && bus_wdata[0]) |=> !sta[0]);

    assert_clear_notfull_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_wr && bus_wdata[1]) |=> !sta[1]);

    assert_tx_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

    assert_irq_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (mask != 4'd0 && sta != 4'd0));

    assert_rx_full_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_ready && !data_rd) |=> !rx_ready);
endmodule

bind mcu_mailbox mbx_checker #(.ADDR_W(ADDR_W)) u_mbx_chk (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .tx_data(tx_data), .rx_valid(rx_valid),
    .rx_ready(rx_ready), .irq(irq), .sta(sta_q), .mask(mask_q)
);

// File: tb/test_mcu_mailbox.sv
// Self-checking bench for mcu_mailbox built with a 4-entry queue depth.
module test_mcu_mailbox;
    localparam int D = 4;
    localparam logic [3:0] A_CTRL = 4'h0, A_DATA = 4'h4, A_STAT = 4'h8, A_NONE = 4'hC;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        tx_valid, rx_ready, irq;
    logic        tx_ready = 1'b0, rx_valid = 1'b0;
    logic [7:0]  tx_data;
    logic [7:0]  rx_data = '0;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    mcu_mailbox #(.FIFO_DEPTH(D)) i_mcu_mailbox (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
        .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(posedge clk); #1;
        bus_sel = 1'b0;
    endtask

    task automatic summary;
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        summary();
        $finish;
    end

    initial begin
        logic [31:0] v;
        // R11: state while reset is held
        repeat (2) @(posedge clk);
        rd(A_STAT, v); check("R11 status in reset", v, 0);
        rd(A_CTRL, v); check("R11 control in reset", v, 0);
        check("R11 irq in reset", {31'b0, irq}, 0);
        check("R11 tx_valid in reset", {31'b0, tx_valid}, 0);
        @(negedge clk) rst_n = 1'b1;

        // R2: empty and not-full latch after first edge
        rd(A_STAT, v); check("R2 status after reset", v, 32'h3);
        // R3: clear then re-set while condition holds
        wr(A_STAT, 32'h3);
        rd(A_STAT, v); check("R3 status right after clear", v, 0);
        rd(A_STAT, v); check("R3 status re-set", v, 32'h3);
        wr(A_STAT, 32'h0);
        rd(A_STAT, v); check("R3 writing zero no effect", v, 32'h3);

        // R5/R6: sweep all mask values against status 0x3
        for (int m = 0; m < 16; m++) begin
            wr(A_CTRL, {24'b0, m[3:0], 4'hF});
            @(negedge clk);
            check("R6 irq vs mask", {31'b0, irq}, {31'b0, ((m & 3) != 0)});
            rd(A_CTRL, v);
            check("R5 control readback", v, {24'b0, m[3:0], 4'(m & 3)});
        end
        wr(A_CTRL, 32'h0);

        // R7: fill past depth, extra writes dropped
        for (int i = 0; i < D + 2; i++) wr(A_DATA, 32'hFFFF_FFA0 + i);
        wr(A_STAT, 32'hF);
        rd(A_STAT, v); check("R3 status after clear all", v, 0);
        rd(A_STAT, v); check("R2 full queue keeps not-full clear", v, 0);
        @(negedge clk);
        check("R9 head held while not ready", {24'b0, tx_data}, 32'hA0);

        // R9: drain in order
        for (int i = 0; i < D; i++) begin
            @(negedge clk);
            check("R9 tx_valid during drain", {31'b0, tx_valid}, 1);
            check("R9 tx order", {24'b0, tx_data}, 32'hA0 + i);
            tx_ready = 1'b1;
            @(posedge clk); #1 tx_ready = 1'b0;
        end
        @(negedge clk);
        check("R7 dropped writes not queued", {31'b0, tx_valid}, 0);
        @(posedge clk);
        rd(A_STAT, v); check("R2 empty flags re-latched", v, 32'h3);

        // R10/R4: overfill incoming queue
        for (int i = 0; i < D + 2; i++) begin
            @(negedge clk);
            rx_valid = 1'b1; rx_data = 8'h50 + 8'(i);
            check("R10 rx_ready vs fill", {31'b0, rx_ready}, {31'b0, (i < D)});
            @(posedge clk); #1;
        end
        rx_valid = 1'b0;
        rd(A_STAT, v); check("R4 overflow and not-empty set", v & 32'hC, 32'hC);
        // R8: read back in order, then empty read
        for (int i = 0; i < D; i++) begin
            rd(A_DATA, v); check("R8 rx order", v, 32'h50 + i);
        end
        rd(A_DATA, v); check("R8 empty read returns 0", v, 0);
        wr(A_STAT, 32'h4);
        rd(A_STAT, v); check("R4 overflow sticky after other clear", v & 32'hC, 32'h8);

        // R4: overflow and clear on the same edge
        for (int i = 0; i < D; i++) begin
            @(negedge clk);
            rx_valid = 1'b1; rx_data = 8'h60 + 8'(i);
            @(posedge clk); #1;
        end
        @(negedge clk);
        rx_valid = 1'b1; rx_data = 8'hEE;
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = A_STAT; bus_wdata = 32'h8;
        @(posedge clk); #1;
        rx_valid = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0;
        rd(A_STAT, v); check("R4 event beats clear", v & 32'h8, 32'h8);
        wr(A_STAT, 32'h8);
        rd(A_STAT, v); check("R4 overflow cleared", v & 32'h8, 0);
        for (int i = 0; i < D; i++) begin
            rd(A_DATA, v); check("R4 dropped byte absent", v, 32'h60 + i);
        end
        rd(A_DATA, v); check("R8 empty after drain", v, 0);

        // R1: unmapped slot and upper bits
        wr(A_STAT, 32'hF);
        wr(A_NONE, 32'hFFFF_FFFF);
        rd(A_NONE, v); check("R1 unmapped slot reads 0", v, 0);
        rd(A_CTRL, v); check("R1 unmapped write no effect", v, 0);
        wr(A_CTRL, 32'hFFFF_FFF0);
        rd(A_CTRL, v); check("R1 upper bits zero, R5 requests", v, 32'hF3);
        check("R6 irq with all masks", {31'b0, irq}, 1);
        wr(A_CTRL, 32'h40);
        wr(A_STAT, 32'hF);
        @(negedge clk);
        check("R6 irq off with only rx mask", {31'b0, irq}, 0);

        // R6: interrupt from incoming data
        @(negedge clk) rx_valid = 1'b1; rx_data = 8'h77;
        @(posedge clk); #1 rx_valid = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check("R6 irq on rx data", {31'b0, irq}, 1);
        rd(A_DATA, v); check("R8 single byte", v, 32'h77);
        wr(A_STAT, 32'h4);
        @(negedge clk);
        check("R6 irq drops after clear", {31'b0, irq}, 0);
        @(negedge clk);
        check("R3 drained flag stays clear", {31'b0, irq}, 0);

        summary();
        $finish;
    end
endmodule